// File: doc/BRIEF.md
# Predicated Branch Resolution Unit

This block resolves every branch in one instruction group of a 64-bit processor that fetches 16-byte bundles. A group holds a fixed number of branch slots in program order. Each slot carries a branch kind, a target mode, a qualifying predicate index, a displacement field, a source branch-register index and a link branch-register index. The block also holds the predicate register file, which has one write port. The branch register file arrives as a flat input vector.

When `grp_valid_i` is high, the block checks each slot's qualifying predicate. It picks the first slot in program order whose branch fires and computes the bundle-aligned target of that branch. It then issues a link write if the winner is a call, and raises a kill bit for every slot that follows the winner. If no branch fires, the next address is the following bundle. All results are registered and appear one cycle after the group, together with a valid strobe.

Top module: `br_resolve`

## Requirements
- R1: `res_valid_o` equals `grp_valid_i` of the previous clock edge. While `res_valid_o` is low, `taken_o` and `link_we_o` are low. After reset, all outputs are zero.
- R2: A slot fires only when its kind is not none and the predicate register named by its qualifying index reads 1. Predicate register 0 always reads 1, and writes to it are ignored. A write through `pr_we_i` is visible to groups presented on later edges. Every other predicate register resets to 0.
- R3: Relative mode (mode code 0) targets the aligned bundle address plus the sign-extended low 21 bits of the displacement field times 16. Bits above bit 20 are ignored.
- R4: Long mode (mode code 1) uses all 60 displacement bits, sign-extended, times 16, added to the aligned bundle address. A long branch occupies its own slot and the next one, so the fields of the next slot are ignored. A long branch in the last slot is not a branch.
- R5: Indirect mode (mode codes 2 and 3) targets the selected branch register with its low 4 bits cleared. A return (kind code 3) always uses the branch register, whatever its mode.
- R6: Among the slots that fire, the lowest-numbered one wins. `taken_o` is raised and `taken_slot_o` gives its index.
- R7: A winning call (kind code 2) raises `link_we_o` with `link_idx_o` set to its link index. The link address is the aligned bundle address plus 16. No other kind raises `link_we_o`.
- R8: When a branch is taken, bit j of `kill_mask_o` is set for every slot j after the last slot the winner occupies. All other bits are clear.
- R9: When nothing is taken, `next_addr_o` is the aligned bundle address plus 16. `taken_o`, `link_we_o` and `kill_mask_o` are all zero.
- R10: A slot whose kind is none (code 0) never fires, whatever its predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_valid_i | input | 1 | Group presented this cycle |
| bundle_addr_i | input | ADDR_W | Address of the bundle holding the group |
| slot_kind_i | input | 2*N_SLOTS | Kind per slot: 0 none, 1 cond, 2 call, 3 return |
| slot_mode_i | input | 2*N_SLOTS | Target mode per slot: 0 relative, 1 long, 2/3 indirect |
| slot_qp_i | input | QP_W*N_SLOTS | Qualifying predicate index per slot |
| slot_disp_i | input | LONG_W*N_SLOTS | Displacement per slot, in bundles |
| slot_bsrc_i | input | BR_W*N_SLOTS | Source branch register per slot |
| slot_blink_i | input | BR_W*N_SLOTS | Link branch register per slot |
| br_file_i | input | ADDR_W*N_BREG | Branch register file contents |
| pr_we_i | input | 1 | Predicate write enable |
| pr_waddr_i | input | QP_W | Predicate write index |
| pr_wdata_i | input | 1 | Predicate write value |
| res_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | A branch was taken |
| taken_slot_o | output | SLOT_W | Index of the winning slot |
| next_addr_o | output | ADDR_W | Next bundle address |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | BR_W | Link register index |
| link_addr_o | output | ADDR_W | Link address |
| kill_mask_o | output | N_SLOTS | Slots squashed after the winner |

## Verification
The hardest case to reach is a long branch whose predicate is false while a later slot fires. The slot it covers carries a live, true-predicated branch that must still lose to a slot beyond it. A second hard case is a long branch placed in the last slot. Both need the vector table to fill the shadowed slot with fields that would win if the coverage logic were wrong. The predicate file is also driven through its write port before the table runs, including a write of 0 to register 0, so that the true and false predicates the vectors rely on, and the always-true register, come from real state rather than from the reset value.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_COND = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    TM_REL  = 2'd0,
    TM_LONG = 2'd1,
    TM_IND  = 2'd2,
    TM_IND2 = 2'd3
  } tgt_mode_e;
endpackage

// File: rtl/br_pred_file.sv
module br_pred_file #(
  parameter int N_PRED  = 64,
  parameter int N_RD    = 3,
  localparam int QP_W   = $clog2(N_PRED)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [QP_W-1:0]      waddr_i,
  input  logic                 wdata_i,
  input  logic [N_RD*QP_W-1:0] raddr_i,
  output logic [N_RD-1:0]      rdata_o
);
  logic [N_PRED-1:0] regs_q;

  // entry 0 resets to 1 and is never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= N_PRED'(1);
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g] = regs_q[raddr_i[g*QP_W +: QP_W]];
  end
endmodule

// File: rtl/br_slot_eval.sv
module br_slot_eval
  import br_resolve_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int REL_W   = 21,
  parameter int LONG_W  = 60,
  parameter int B_LSB   = 4
) (
  input  logic [1:0]        kind_i,
  input  logic [1:0]        mode_i,
  input  logic              pred_i,
  input  logic [LONG_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] breg_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              fire_o,
  output logic              long_o,
  output logic              call_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'((1 << B_LSB) - 1);

  br_kind_e  kind;
  tgt_mode_e mode;
  logic      is_br, is_ind;
  logic signed [REL_W-1:0]  d_rel;
  logic signed [LONG_W-1:0] d_long;
  logic [ADDR_W-1:0] off_rel, off_long;

  assign kind   = br_kind_e'(kind_i);
  assign mode   = tgt_mode_e'(mode_i);
  assign is_br  = (kind != BK_NONE);
  assign is_ind = (kind == BK_RET) || (mode == TM_IND) || (mode == TM_IND2);
  assign long_o = is_br && !is_ind && (mode == TM_LONG);
  assign fire_o = is_br && pred_i;
  assign call_o = (kind == BK_CALL);

  assign d_rel    = disp_i[REL_W-1:0];
  assign d_long   = disp_i;
  assign off_rel  = ADDR_W'(d_rel) << B_LSB;
  assign off_long = ADDR_W'(d_long) << B_LSB;

  always_comb begin
    if (is_ind)      target_o = breg_i & ALIGN;
    else if (long_o) target_o = base_i + off_long;
    else             target_o = base_i + off_rel;
  end
endmodule

// File: rtl/br_pick.sv
module br_pick #(
  parameter int N_SLOTS = 3,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [N_SLOTS-1:0] fire_i,
  input  logic [N_SLOTS-1:0] long_i,
  output logic               hit_o,
  output logic [SLOT_W-1:0]  win_o,
  output logic [N_SLOTS-1:0] kill_o
);
  logic [N_SLOTS-1:0] covered, elig;
  int unsigned        win_end;

  // a long form swallows the slot after it; a long form in the last slot is void
  always_comb begin
    covered = '0;
    elig    = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (i == N_SLOTS - 1) begin
        elig[i] = fire_i[i] && !covered[i] && !long_i[i];
      end else begin
        elig[i] = fire_i[i] && !covered[i];
        covered[i+1] = long_i[i] && !covered[i];
      end
    end
  end

  always_comb begin
    hit_o   = 1'b0;
    win_o   = '0;
    win_end = 0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit_o   = 1'b1;
        win_o   = SLOT_W'(i);
        win_end = long_i[i] ? unsigned'(i + 1) : unsigned'(i);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N_SLOTS; j++) begin
      kill_o[j] = hit_o && (unsigned'(j) > win_end);
    end
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_resolve_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int N_SLOTS  = 3,
  parameter int N_PRED   = 64,
  parameter int N_BREG   = 8,
  parameter int REL_W    = 21,
  parameter int LONG_W   = 60,
  parameter int B_LSB    = 4,
  localparam int QP_W    = $clog2(N_PRED),
  localparam int BR_W    = $clog2(N_BREG),
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     grp_valid_i,
  input  logic [ADDR_W-1:0]        bundle_addr_i,
  input  logic [2*N_SLOTS-1:0]     slot_kind_i,
  input  logic [2*N_SLOTS-1:0]     slot_mode_i,
  input  logic [QP_W*N_SLOTS-1:0]  slot_qp_i,
  input  logic [LONG_W*N_SLOTS-1:0] slot_disp_i,
  input  logic [BR_W*N_SLOTS-1:0]  slot_bsrc_i,
  input  logic [BR_W*N_SLOTS-1:0]  slot_blink_i,
  input  logic [ADDR_W*N_BREG-1:0] br_file_i,
  input  logic                     pr_we_i,
  input  logic [QP_W-1:0]          pr_waddr_i,
  input  logic                     pr_wdata_i,
  output logic                     res_valid_o,
  output logic                     taken_o,
  output logic [SLOT_W-1:0]        taken_slot_o,
  output logic [ADDR_W-1:0]        next_addr_o,
  output logic                     link_we_o,
  output logic [BR_W-1:0]          link_idx_o,
  output logic [ADDR_W-1:0]        link_addr_o,
  output logic [N_SLOTS-1:0]       kill_mask_o
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'((1 << B_LSB) - 1);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1 << B_LSB);

  logic [ADDR_W-1:0]  base, seq_addr;
  logic [N_SLOTS-1:0] pred, fire, is_long, is_call;
  logic [ADDR_W-1:0]  tgt [N_SLOTS];
  logic               hit;
  logic [SLOT_W-1:0]  win;
  logic [N_SLOTS-1:0] kill;
  logic               win_call;
  logic [BR_W-1:0]    win_link;
  logic [ADDR_W-1:0]  win_tgt;

  assign base     = bundle_addr_i & ALIGN;
  assign seq_addr = base + STEP;

  br_pred_file #(
    .N_PRED (N_PRED),
    .N_RD   (N_SLOTS)
  ) i_pred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pr_we_i),
    .waddr_i (pr_waddr_i),
    .wdata_i (pr_wdata_i),
    .raddr_i (slot_qp_i),
    .rdata_o (pred)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic [BR_W-1:0]   bsrc;
    logic [ADDR_W-1:0] breg;
    assign bsrc = slot_bsrc_i[g*BR_W +: BR_W];
    assign breg = br_file_i[bsrc*ADDR_W +: ADDR_W];

    br_slot_eval #(
      .ADDR_W (ADDR_W),
      .REL_W  (REL_W),
      .LONG_W (LONG_W),
      .B_LSB  (B_LSB)
    ) i_eval (
      .kind_i   (slot_kind_i[2*g +: 2]),
      .mode_i   (slot_mode_i[2*g +: 2]),
      .pred_i   (pred[g]),
      .disp_i   (slot_disp_i[g*LONG_W +: LONG_W]),
      .breg_i   (breg),
      .base_i   (base),
      .fire_o   (fire[g]),
      .long_o   (is_long[g]),
      .call_o   (is_call[g]),
      .target_o (tgt[g])
    );
  end

  br_pick #(
    .N_SLOTS (N_SLOTS)
  ) i_pick (
    .fire_i (fire),
    .long_i (is_long),
    .hit_o  (hit),
    .win_o  (win),
    .kill_o (kill)
  );

  always_comb begin
    win_call = 1'b0;
    win_link = '0;
    win_tgt  = seq_addr;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (hit && win == SLOT_W'(i)) begin
        win_call = is_call[i];
        win_link = slot_blink_i[i*BR_W +: BR_W];
        win_tgt  = tgt[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      taken_o      <= 1'b0;
      taken_slot_o <= '0;
      next_addr_o  <= '0;
      link_we_o    <= 1'b0;
      link_idx_o   <= '0;
      link_addr_o  <= '0;
      kill_mask_o  <= '0;
    end else begin
      res_valid_o <= grp_valid_i;
      taken_o     <= grp_valid_i && hit;
      link_we_o   <= grp_valid_i && hit && win_call;
      if (grp_valid_i) begin
        taken_slot_o <= win;
        next_addr_o  <= win_tgt;
        link_idx_o   <= win_link;
        link_addr_o  <= seq_addr;
        kill_mask_o  <= kill;
      end
    end
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int ADDR_W  = 64,
  parameter int N_SLOTS = 3,
  parameter int B_LSB   = 4,
  parameter int SLOT_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               grp_valid_i,
  input logic [ADDR_W-1:0]  bundle_addr_i,
  input logic               res_valid_o,
  input logic               taken_o,
  input logic [SLOT_W-1:0]  taken_slot_o,
  input logic [ADDR_W-1:0]  next_addr_o,
  input logic               link_we_o,
  input logic [ADDR_W-1:0]  link_addr_o,
  input logic [N_SLOTS-1:0] kill_mask_o
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'((1 << B_LSB) - 1);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1 << B_LSB);

  assert_valid_lag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(grp_valid_i));

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!taken_o && !link_we_o));

  assert_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((next_addr_o & ~ALIGN) == '0));

  assert_winner_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (!kill_mask_o[0] && !kill_mask_o[taken_slot_o]));

  assert_link_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (taken_o && link_addr_o == ($past(bundle_addr_i) & ALIGN) + STEP));

  assert_fallthrough_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !taken_o) |->
      (kill_mask_o == '0 && next_addr_o == ($past(bundle_addr_i) & ALIGN) + STEP));
endmodule

bind br_resolve br_resolve_chk #(
  .ADDR_W  (ADDR_W),
  .N_SLOTS (N_SLOTS),
  .B_LSB   (B_LSB),
  .SLOT_W  (SLOT_W)
) i_br_resolve_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .grp_valid_i   (grp_valid_i),
  .bundle_addr_i (bundle_addr_i),
  .res_valid_o   (res_valid_o),
  .taken_o       (taken_o),
  .taken_slot_o  (taken_slot_o),
  .next_addr_o   (next_addr_o),
  .link_we_o     (link_we_o),
  .link_addr_o   (link_addr_o),
  .kill_mask_o   (kill_mask_o)
);

// File: tb/test_br_resolve.sv
module test_br_resolve;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam logic [63:0] B = 64'h0000_0000_0010_0000;

  typedef struct packed {
    logic [63:0]  addr;
    logic [5:0]   kind;
    logic [5:0]   mode;
    logic [17:0]  qp;
    logic [179:0] disp;
    logic [8:0]   bsrc;
    logic [8:0]   blink;
    logic         tk;
    logic [1:0]   slot;
    logic [63:0]  nxt;
    logic         lwe;
    logic [2:0]   lidx;
    logic [63:0]  lnk;
    logic [2:0]   kill;
  } vec_t;

  localparam int N_VEC = 13;
  // fields per slot packed {s2,s1,s0}; kind 0 none 1 cond 2 call 3 ret; mode 0 rel 1 long 2 ind
  localparam vec_t VECS [N_VEC] = '{
    // R10: all none, PR0 qualifies but nothing fires; R9 fall-through
    '{B, {2'd0,2'd0,2'd0}, 6'd0, {6'd0,6'd0,6'd0}, 180'd0, 9'd0, 9'd0,
      1'b0, 2'd0, 64'h100010, 1'b0, 3'd0, 64'd0, 3'b000},
    // R2 false pred in s0, R3 upper disp bits ignored, R6 s1 wins
    '{B, {2'd0,2'd1,2'd1}, 6'd0, {6'd0,6'd1,6'd2}, {60'd0, 60'hFFFFFFFFFE00003, 60'd5}, 9'd0, 9'd0,
      1'b1, 2'd1, 64'h100030, 1'b0, 3'd0, 64'd0, 3'b100},
    // R3 negative relative
    '{B, {2'd0,2'd0,2'd1}, 6'd0, {6'd0,6'd0,6'd1}, {60'd0, 60'd0, 60'h00000000001FFFFE}, 9'd0, 9'd0,
      1'b1, 2'd0, 64'h0FFFE0, 1'b0, 3'd0, 64'd0, 3'b110},
    // R7 call via PR0
    '{B, {2'd0,2'd0,2'd2}, 6'd0, {6'd0,6'd0,6'd0}, {60'd0, 60'd0, 60'h100}, 9'd0, {3'd0,3'd0,3'd5},
      1'b1, 2'd0, 64'h101000, 1'b1, 3'd5, 64'h100010, 3'b110},
    // R4 untaken long covers s1 (true pred), s2 wins
    '{B, {2'd1,2'd1,2'd1}, {2'd0,2'd0,2'd1}, {6'd3,6'd1,6'd2}, {60'd2, 60'd7, 60'd0}, 9'd0, 9'd0,
      1'b1, 2'd2, 64'h100020, 1'b0, 3'd0, 64'd0, 3'b000},
    // R4 long, most negative displacement
    '{B, {2'd0,2'd1,2'd1}, {2'd0,2'd0,2'd1}, {6'd0,6'd1,6'd1}, {60'd0, 60'd9, 60'h800000000000000}, 9'd0, 9'd0,
      1'b1, 2'd0, 64'h8000000000100000, 1'b0, 3'd0, 64'd0, 3'b100},
    // R4 long in last slot is void
    '{B, {2'd2,2'd0,2'd0}, {2'd1,2'd0,2'd0}, 18'd0, {60'd4, 60'd0, 60'd0}, 9'd0, {3'd6,3'd0,3'd0},
      1'b0, 2'd0, 64'h100010, 1'b0, 3'd0, 64'd0, 3'b000},
    // R5 indirect conditional
    '{B, {2'd0,2'd0,2'd1}, {2'd0,2'd0,2'd2}, {6'd0,6'd0,6'd3}, 180'd0, {3'd0,3'd0,3'd2}, 9'd0,
      1'b1, 2'd0, 64'hA02000, 1'b0, 3'd0, 64'd0, 3'b110},
    // R5 return in rel mode still indirect
    '{B, {2'd0,2'd0,2'd3}, 6'd0, 18'd0, {60'd0, 60'd0, 60'd50}, {3'd0,3'd0,3'd4}, 9'd0,
      1'b1, 2'd0, 64'hA04000, 1'b0, 3'd0, 64'd0, 3'b110},
    // R7 indirect call, unaligned bundle address
    '{64'h100007, {2'd0,2'd0,2'd2}, {2'd0,2'd0,2'd2}, {6'd0,6'd0,6'd1}, 180'd0, {3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd3},
      1'b1, 2'd0, 64'hA01000, 1'b1, 3'd3, 64'h100010, 3'b110},
    // R7 untaken call no link, return in s2 wins
    '{B, {2'd3,2'd0,2'd2}, 6'd0, {6'd1,6'd0,6'd2}, 180'd0, {3'd7,3'd0,3'd0}, {3'd0,3'd0,3'd2},
      1'b1, 2'd2, 64'hA07000, 1'b0, 3'd0, 64'd0, 3'b000},
    // R9 nothing fires, high unaligned address
    '{64'h123456789ABCDEF4, {2'd1,2'd2,2'd1}, 6'd0, {6'd2,6'd4,6'd5}, {60'd1, 60'd2, 60'd3}, 9'd0, 9'd0,
      1'b0, 2'd0, 64'h123456789ABCDF00, 1'b0, 3'd0, 64'd0, 3'b000},
    // R4 long in s1 taken, s2 covered
    '{B, {2'd0,2'd1,2'd1}, {2'd0,2'd1,2'd0}, {6'd0,6'd1,6'd2}, {60'd0, 60'hFFFFFFFFFFFFFFF, 60'd0}, 9'd0, 9'd0,
      1'b1, 2'd1, 64'h0FFFF0, 1'b0, 3'd0, 64'd0, 3'b000}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         grp_valid_i = 1'b0;
  logic [63:0]  bundle_addr_i = '0;
  logic [5:0]   slot_kind_i = '0, slot_mode_i = '0;
  logic [17:0]  slot_qp_i = '0;
  logic [179:0] slot_disp_i = '0;
  logic [8:0]   slot_bsrc_i = '0, slot_blink_i = '0;
  logic [511:0] br_file_i;
  logic         pr_we_i = 1'b0;
  logic [5:0]   pr_waddr_i = '0;
  logic         pr_wdata_i = 1'b0;
  logic         res_valid_o, taken_o, link_we_o;
  logic [1:0]   taken_slot_o;
  logic [63:0]  next_addr_o, link_addr_o;
  logic [2:0]   link_idx_o, kill_mask_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  br_resolve i_br_resolve (
    .clk_i, .rst_ni, .grp_valid_i, .bundle_addr_i,
    .slot_kind_i, .slot_mode_i, .slot_qp_i, .slot_disp_i,
    .slot_bsrc_i, .slot_blink_i, .br_file_i,
    .pr_we_i, .pr_waddr_i, .pr_wdata_i,
    .res_valid_o, .taken_o, .taken_slot_o, .next_addr_o,
    .link_we_o, .link_idx_o, .link_addr_o, .kill_mask_o
  );

  always_comb
    for (int k = 0; k < 8; k++) br_file_i[k*64 +: 64] = 64'hA0_0000 + 64'(k) * 64'h1000 + 64'd5;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_pred(input logic [5:0] idx, input logic val);
    @(negedge clk_i);
    pr_we_i = 1'b1; pr_waddr_i = idx; pr_wdata_i = val;
    @(negedge clk_i);
    pr_we_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    @(negedge clk_i);
    grp_valid_i = 1'b1; bundle_addr_i = v.addr;
    slot_kind_i = v.kind; slot_mode_i = v.mode; slot_qp_i = v.qp;
    slot_disp_i = v.disp; slot_bsrc_i = v.bsrc; slot_blink_i = v.blink;
    @(negedge clk_i);
    grp_valid_i = 1'b0;
    $display("vector %0d", n);
    chk("R1 res_valid", 64'(res_valid_o), 64'd1);
    chk("R6 taken", 64'(taken_o), 64'(v.tk));
    if (v.tk) chk("R6 taken_slot", 64'(taken_slot_o), 64'(v.slot));
    chk("R3 next_addr", next_addr_o, v.nxt);
    chk("R7 link_we", 64'(link_we_o), 64'(v.lwe));
    if (v.lwe) begin
      chk("R7 link_idx", 64'(link_idx_o), 64'(v.lidx));
      chk("R7 link_addr", link_addr_o, v.lnk);
    end
    chk("R8 kill_mask", 64'(kill_mask_o), 64'(v.kill));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset res_valid", 64'(res_valid_o), 64'd0);
    chk("R1 reset taken", 64'(taken_o), 64'd0);
    chk("R1 reset link_we", 64'(link_we_o), 64'd0);
    chk("R1 reset next_addr", next_addr_o, 64'd0);
    chk("R1 reset kill", 64'(kill_mask_o), 64'd0);
    rst_ni = 1'b1;

    // R2: predicate setup, write to PR0 must be dropped
    wr_pred(6'd0, 1'b0);
    wr_pred(6'd1, 1'b1);
    wr_pred(6'd3, 1'b1);

    for (int i = 0; i < N_VEC; i++) run_vec(VECS[i], i);

    // R1 valid drops when no group
    @(negedge clk_i);
    chk("R1 idle res_valid", 64'(res_valid_o), 64'd0);
    chk("R1 idle taken", 64'(taken_o), 64'd0);

    // R2 write of PR2 now qualifies s0
    wr_pred(6'd2, 1'b1);
    run_vec('{B, {2'd0,2'd1,2'd1}, 6'd0, {6'd0,6'd1,6'd2}, {60'd0, 60'd3, 60'd5}, 9'd0, 9'd0,
              1'b1, 2'd0, 64'h100050, 1'b0, 3'd0, 64'd0, 3'b110}, 100);
    // R2 clearing PR1 and PR2 leaves nothing taken
    wr_pred(6'd1, 1'b0);
    wr_pred(6'd2, 1'b0);
    run_vec('{B, {2'd0,2'd1,2'd1}, 6'd0, {6'd0,6'd1,6'd2}, {60'd0, 60'd3, 60'd5}, 9'd0, 9'd0,
              1'b0, 2'd0, 64'h100010, 1'b0, 3'd0, 64'd0, 3'b000}, 101);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule